// File: doc/BRIEF.md
# UART Interrupt Priority Identification

This block collects the four interrupt causes of a serial UART and reports them to the CPU. The four causes are a receive line error, received data available, transmit holding register empty and a modem status change. Each cause latches a pending flag when its condition flag rises. A four-bit enable input masks which pending causes take part. The highest-ranked enabled cause is encoded into an 8-bit identification value, and a single interrupt request output is driven high while any enabled cause is pending.

The CPU services an interrupt by reading the identification value and then acting on the cause it reports. Each cause has its own clearing action: reading the line status, reading the receive buffer, reading the modem status, or writing the transmit holding register. The transmit-empty cause can also be cleared by an identification read that reported it. While the identification read strobe is held, the reported value stays frozen at the cause captured on the first cycle of the access. Any cause that arrives during the access is reported only after the strobe is released.

Top module: `uart_irq_ident`

## Requirements
- R1: Causes are ranked line error (highest), received data, transmit empty, modem change (lowest). Bits 2:1 of `ident` carry 2'b11, 2'b10, 2'b01 or 2'b00 respectively for the highest enabled pending cause, so `ident` reads 0x06, 0x04, 0x02 or 0x00.
- R2: Bit 0 of `ident` is 0 while an enabled cause is pending and 1 otherwise; with nothing pending, `ident` reads 0x01.
- R3: Bits 7:3 of `ident` always read 0.
- R4: `int_en` bit 0 enables line error, bit 1 received data, bit 2 transmit empty and bit 3 modem change. A masked cause keeps its pending flag and appears as soon as its enable bit is set.
- R5: `irq` is high exactly when at least one enabled cause is pending.
- R6: A cause becomes pending on the clock edge that follows a rising edge of its condition flag. A flag that stays high does not set it again. When a rising edge and a clearing action fall in the same cycle, the cause stays pending.
- R7: A `rd_line` pulse clears the line error cause, a `rd_rxbuf` pulse clears the received data cause, and a `rd_modem` pulse clears the modem change cause, each from the next edge.
- R8: The transmit-empty cause is cleared by a `wr_txhold` pulse, or by the first cycle of an identification read that reports transmit empty. An identification read that reports another cause leaves it pending.
- R9: On the first cycle of `rd_ident`, `ident` is captured. It is held for as long as `rd_ident` stays high, and it follows the live causes again from the edge at which `rd_ident` is seen low.
- R10: A synchronous active-high `rst` clears every pending cause and any frozen value, so `ident` reads 0x01 and `irq` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_en | input | 4 | Per-cause enable (bit0 line, bit1 rx, bit2 tx, bit3 modem) |
| line_err | input | 1 | Receive line error condition flag |
| rx_ready | input | 1 | Received data available flag |
| tx_empty | input | 1 | Transmit holding register empty flag |
| modem_chg | input | 1 | Modem status change flag |
| rd_ident | input | 1 | Identification register read strobe |
| rd_line | input | 1 | Line status read strobe |
| rd_rxbuf | input | 1 | Receive buffer read strobe |
| rd_modem | input | 1 | Modem status read strobe |
| wr_txhold | input | 1 | Transmit holding register write strobe |
| ident | output | 8 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same edge. The first is a rising condition flag and the clearing action of the same cause. The bench provokes it by raising `line_err` together with `rd_line`, and `tx_empty` together with `wr_txhold`, and expects the cause to stay pending. The second is a new, higher-ranked cause that arrives while an identification read holds the value frozen. The bench raises `line_err` during a held `rd_ident` and expects the old code until the strobe falls, then the line error code.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC   = 4;
    localparam int IDW    = $clog2(NSRC);
    localparam int REGW   = 8;

    // cause index order doubles as priority order (index 0 highest)
    localparam int SRC_LINE  = 0;
    localparam int SRC_RX    = 1;
    localparam int SRC_TX    = 2;
    localparam int SRC_MODEM = 3;

    typedef enum logic [IDW-1:0] {
        ID_MODEM = 2'b00,
        ID_TXE   = 2'b01,
        ID_RXD   = 2'b10,
        ID_LINE  = 2'b11
    } src_id_e;

    function automatic logic [REGW-1:0] make_ident(input logic any, input src_id_e id);
        logic [REGW-1:0] v;
        v = '0;
        if (any) v[IDW:1] = id;
        else     v[0]     = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src (
    input  logic clk,
    input  logic rst,
    input  logic cond_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        st_d      = st_q;
        rise      = cond_i & ~st_q.prev;
        st_d.prev = cond_i;
        // a fresh edge outranks a clear in the same cycle
        st_d.pend = rise | (st_q.pend & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] active_i,
    output logic            any_o,
    output src_id_e         id_o
);
    always_comb begin
        any_o = 1'b0;
        id_o  = ID_MODEM;
        // walk from lowest rank upward so the highest rank wins
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                any_o = 1'b1;
                id_o  = src_id_e'(IDW'(NSRC - 1 - i));
            end
        end
    end
endmodule

// File: rtl/uart_irq_freeze.sv
module uart_irq_freeze
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_i,
    input  logic [REGW-1:0] live_i,
    output logic            capture_o,
    output logic [REGW-1:0] ident_o
);
    typedef struct packed {
        logic            hold;
        logic [REGW-1:0] snap;
    } frz_st_t;

    frz_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        capture_o = rd_i & ~st_q.hold;
        st_d.hold = rd_i;
        if (capture_o) st_d.snap = live_i;
        ident_o   = st_q.hold ? st_q.snap : live_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{hold: 1'b0, snap: REGW'(1)};
        else     st_q <= st_d;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] int_en,
    input  logic            line_err,
    input  logic            rx_ready,
    input  logic            tx_empty,
    input  logic            modem_chg,
    input  logic            rd_ident,
    input  logic            rd_line,
    input  logic            rd_rxbuf,
    input  logic            rd_modem,
    input  logic            wr_txhold,
    output logic [REGW-1:0] ident,
    output logic            irq
);
    logic [NSRC-1:0] cond, clr, pend, active;
    logic            any_live, capture;
    src_id_e         top_id;
    logic [REGW-1:0] live_ident;

    always_comb begin
        cond            = '0;
        cond[SRC_LINE]  = line_err;
        cond[SRC_RX]    = rx_ready;
        cond[SRC_TX]    = tx_empty;
        cond[SRC_MODEM] = modem_chg;

        clr             = '0;
        clr[SRC_LINE]   = rd_line;
        clr[SRC_RX]     = rd_rxbuf;
        clr[SRC_TX]     = wr_txhold | (capture & any_live & (top_id == ID_TXE));
        clr[SRC_MODEM]  = rd_modem;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        uart_irq_src u_src (
            .clk    (clk),
            .rst    (rst),
            .cond_i (cond[g]),
            .clr_i  (clr[g]),
            .pend_o (pend[g])
        );
    end

    assign active = pend & int_en;

    uart_irq_prio u_prio (
        .active_i (active),
        .any_o    (any_live),
        .id_o     (top_id)
    );

    assign live_ident = make_ident(any_live, top_id);

    uart_irq_freeze u_freeze (
        .clk       (clk),
        .rst       (rst),
        .rd_i      (rd_ident),
        .live_i    (live_ident),
        .capture_o (capture),
        .ident_o   (ident)
    );

    assign irq = any_live;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] int_en,
    input logic       rd_ident,
    input logic [7:0] ident,
    input logic       irq
);
    logic rd_prev_q;
    logic rst_prev_q;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
        if (rst) rd_prev_q <= 1'b0;
        else     rd_prev_q <= rd_ident;
    end

    // R3
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ident[7:3] == 5'b0);

    // R2: outside a read, bit 0 mirrors the absence of a request
    a_r2_pend_bit: assert property (@(posedge clk) disable iff (rst)
        (!rd_ident && !rd_prev_q) |-> (ident[0] == !irq));

    // R9: value stays put while the strobe stays high
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (rd_ident && rd_prev_q) |-> $stable(ident));

    // R5
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (int_en == 4'b0) |-> !irq);

    // R10
    a_r10_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        rst_prev_q |-> (!irq && ident == 8'h01));
endmodule

bind uart_irq_ident uart_irq_ident_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .int_en   (int_en),
    .rd_ident (rd_ident),
    .ident    (ident),
    .irq      (irq)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] int_en;
    logic       line_err, rx_ready, tx_empty, modem_chg;
    logic       rd_ident, rd_line, rd_rxbuf, rd_modem, wr_txhold;
    logic [7:0] ident;
    logic       irq;

    always #5 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk(clk), .rst(rst), .int_en(int_en),
        .line_err(line_err), .rx_ready(rx_ready), .tx_empty(tx_empty), .modem_chg(modem_chg),
        .rd_ident(rd_ident), .rd_line(rd_line), .rd_rxbuf(rd_rxbuf), .rd_modem(rd_modem),
        .wr_txhold(wr_txhold), .ident(ident), .irq(irq)
    );

    typedef struct {
        logic [7:0] id;
        logic       rq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    int   cycles = 0;
    bit   done  = 0;

    // monitor: compares shortly after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (ident !== e.id || irq !== e.rq) begin
                bad++;
                $display("FAIL %s: ident=%02h irq=%0b expected ident=%02h irq=%0b",
                         e.tag, ident, irq, e.id, e.rq);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // driver: inputs set at negedge, expectation for the following edge
    task automatic step(input logic [7:0] id, input logic rq, input string tag);
        exp_t e;
        e.id = id; e.rq = rq; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        rst = 1; int_en = 4'hF;
        line_err = 0; rx_ready = 0; tx_empty = 0; modem_chg = 0;
        rd_ident = 0; rd_line = 0; rd_rxbuf = 0; rd_modem = 0; wr_txhold = 0;
        @(negedge clk);
        step(8'h01, 0, "R10 reset state");
        rst = 0;
        step(8'h01, 0, "R2 idle reads 01");

        // priority chain
        tx_empty = 1;  step(8'h02, 1, "R6 tx rise sets pending");
        modem_chg = 1; step(8'h02, 1, "R1 tx above modem");
        rx_ready = 1;  step(8'h04, 1, "R1 rx above tx");
        line_err = 1;  step(8'h06, 1, "R1 R3 line highest");
        line_err = 0; rd_line = 1;   step(8'h04, 1, "R7 line status read clears");
        rd_line = 0; rx_ready = 0; rd_rxbuf = 1; step(8'h02, 1, "R7 rxbuf read clears");
        rd_rxbuf = 0; wr_txhold = 1; step(8'h00, 1, "R8 thr write clears tx");
        wr_txhold = 0; step(8'h00, 1, "R6 held flag does not retrigger");
        modem_chg = 0; rd_modem = 1; step(8'h01, 0, "R7 modem read clears");
        rd_modem = 0;

        // masking
        int_en = 4'b1110; line_err = 1; step(8'h01, 0, "R4 R5 masked cause hidden");
        int_en = 4'hF; step(8'h06, 1, "R4 masked cause retained");
        line_err = 0; rd_line = 1; step(8'h01, 0, "R7 clear line");
        rd_line = 0;

        // identification read clears tx
        tx_empty = 0; step(8'h01, 0, "R8 setup");
        tx_empty = 1; step(8'h02, 1, "R6 tx set");
        rd_ident = 1; step(8'h02, 0, "R8 ident read clears tx, value frozen");
        rd_ident = 0; step(8'h01, 0, "R9 release");

        // freeze with late arrival; read of rx leaves tx
        tx_empty = 0; step(8'h01, 0, "R8 setup");
        tx_empty = 1; step(8'h02, 1, "R6 tx set again");
        rx_ready = 1; step(8'h04, 1, "R1 rx over tx");
        rd_ident = 1; step(8'h04, 1, "R9 captured rx");
        line_err = 1; step(8'h04, 1, "R9 frozen during late line error");
        step(8'h04, 1, "R9 still frozen");
        rd_ident = 0; step(8'h06, 1, "R9 release shows line");
        line_err = 0; rd_line = 1; step(8'h04, 1, "R7 line cleared");
        rd_line = 0; rx_ready = 0; rd_rxbuf = 1; step(8'h02, 1, "R8 tx survived ident read of rx");
        rd_rxbuf = 0; wr_txhold = 1; step(8'h01, 0, "R8 thr write");
        wr_txhold = 0;

        // same-cycle set and clear
        line_err = 1; step(8'h06, 1, "R6 line set");
        line_err = 0; step(8'h06, 1, "R6 line stays pending");
        line_err = 1; rd_line = 1; step(8'h06, 1, "R6 rise beats clear");
        line_err = 0; step(8'h01, 0, "R7 line cleared");
        rd_line = 0;
        tx_empty = 0; step(8'h01, 0, "R6 setup");
        tx_empty = 1; wr_txhold = 1; step(8'h02, 1, "R6 tx rise beats thr write");
        tx_empty = 0; step(8'h01, 0, "R8 thr write clears");
        wr_txhold = 0;

        // reset mid-run
        line_err = 1; step(8'h06, 1, "R10 setup");
        rst = 1; rd_ident = 1; step(8'h01, 0, "R10 reset clears pending");
        rst = 0; rd_ident = 0; line_err = 0; step(8'h01, 0, "R10 stays clear");

        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule